// File: doc/BRIEF.md
# Outbound Address Window Translator

This block turns addresses issued by local masters into a fixed outbound region into wider remote-bus addresses. The region is split into a bank of equal-sized windows that sit back to back from the region base. One shared size index sets every window to a power-of-two number of megabytes. Each window holds two programmed words. The low word carries the upper bits of the remote base and a per-window enable flag. The high word gives the upper half of the remote address.

A small register port with one address bus serves both writes and reads. Through it software sets the size index, the per-window words and a command word, and one bit of the command word switches translation on for the whole block. On the lookup side the block takes a local address with a valid strobe. One clock later it returns the remote address, a hit flag and a miss flag. A miss is raised for any address the block cannot translate: one outside the windows, one that lands in a disabled window, or any address while translation is switched off.

Top module: `ob_xlat_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads back zero and a lookup produces a miss.
- R2: A read returns the last value written. Reads target the command word at 0x004, the size word at 0x030 (only bits 2:0 are stored and upper bits read as zero), and per-window words: the low word of window n at 0x200+8n and the high word at 0x204+8n. Read data appears on reg_rdata the cycle after reg_rd_en and holds until the next read.
- R3: Bit 1 of the command word is the global translation enable. Its other bits are stored but do not affect translation. Writes to any other register leave the command word unchanged.
- R4: With size index s, each window spans 2^(20+s) bytes, and window i covers region base + i·2^(20+s) up to the start of the next window.
- R5: On a hit, out_addr[63:32] is the window's high word. out_addr[31:0] is the window's low word with its lowest 20+s bits replaced by the address's offset inside the window.
- R6: Bit 0 of a window's low word enables that window; a lookup that lands in a window with bit 0 clear is a miss.
- R7: While command bit 1 is clear, every lookup is a miss.
- R8: An address below the region base, or at or beyond the end of the last window, is a miss.
- R9: out_valid, out_hit, out_miss and out_addr update exactly one clock after xl_valid is sampled. With xl_valid low, the next cycle shows out_valid, out_hit and out_miss all low.
- R10: For a valid lookup exactly one of out_hit and out_miss is set, and out_addr is zero whenever out_hit is low.
- R11: A register write and a lookup in the same cycle: the lookup uses the register values from before that write.
- R12: A register address that is not listed in R2 (including one not word-aligned) reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address, shared by read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after a read |
| xl_valid | input | 1 | Lookup request strobe |
| xl_addr | input | 32 | Local address to translate |
| out_valid | output | 1 | Lookup result valid |
| out_hit | output | 1 | Address translated |
| out_miss | output | 1 | Address not translated |
| out_addr | output | 64 | Translated remote address, zero on a miss |

## Verification
The two functions that can meet in one cycle are a register write and a lookup. A write that changes the window under lookup, or the global enable, can land on the very edge where the lookup is sampled. The bench provokes this on purpose by driving a write that disables window 0 in the same cycle as a lookup into window 0. It expects a hit built from the old words, then a miss on the next lookup. The random phase mixes writes and lookups the same way and judges each result against a model that applies writes only after the lookup edge.

// File: rtl/ob_xlat_pkg.sv
// Shared constants and types for the outbound window translator.
// Assumes a 12-bit register byte address space and word-aligned accesses.
package ob_xlat_pkg;

    // One megabyte: the window granule.
    localparam int unsigned MB_SHIFT     = 20;
    // Width of the shared size index.
    localparam int unsigned SIZE_IDX_W   = 3;
    // Bit positions that the lookup logic decodes.
    localparam int unsigned CMD_XLAT_BIT = 1;
    localparam int unsigned WIN_EN_BIT   = 0;

    // Register byte offsets.
    localparam int unsigned OFS_CMD      = 32'h004;
    localparam int unsigned OFS_SIZE     = 32'h030;
    localparam int unsigned OFS_WIN_BASE = 32'h200;
    localparam int unsigned WIN_STRIDE   = 8;

    // Register kinds selected by the address decoder.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_SIZE = 2'd2,
        SEL_WIN  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/ob_xlat_decode.sv
// Register address decoder.
// Turns a byte address into a register kind, a window number and a
// low/high word select. Assumes word-aligned addresses; any other address
// decodes as SEL_NONE.
module ob_xlat_decode
    import ob_xlat_pkg::*;
#(
    parameter int unsigned REG_AW  = 12,
    parameter int unsigned NUM_WIN = 32,
    localparam int unsigned IDX_W  = $clog2(NUM_WIN)
) (
    input  logic [REG_AW-1:0] addr,
    output reg_sel_e          kind,
    output logic              hi_word,
    output logic [IDX_W-1:0]  win
);

    localparam int unsigned WIN_END = OFS_WIN_BASE + WIN_STRIDE * NUM_WIN;

    logic [31:0] addr32;
    logic [31:0] rel;
    logic        aligned;

    // Classify the address and split out the window fields.
    always_comb begin
        addr32  = 32'(addr);
        rel     = addr32 - OFS_WIN_BASE;
        aligned = (addr[1:0] == 2'b00);
        win     = rel[IDX_W+2:3];
        hi_word = addr[2];
        if (aligned && addr32 == OFS_CMD) begin
            kind = SEL_CMD;
        end else if (aligned && addr32 == OFS_SIZE) begin
            kind = SEL_SIZE;
        end else if (aligned && addr32 >= OFS_WIN_BASE && addr32 < WIN_END) begin
            kind = SEL_WIN;
        end else begin
            kind = SEL_NONE;
        end
    end

endmodule

// File: rtl/ob_xlat_regs.sv
// Register file for the translator.
// Holds the command word, the size index and two words per window. Writes
// land at the clock edge. Reads are registered and return pre-edge values,
// so a write and a read to the same address in one cycle return the old
// value. Unmapped reads return zero.
module ob_xlat_regs
    import ob_xlat_pkg::*;
#(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned NUM_WIN = 32,
    localparam int unsigned IDX_W  = $clog2(NUM_WIN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  reg_sel_e              kind,
    input  logic                  hi_word,
    input  logic [IDX_W-1:0]      win,
    input  logic [WORD_W-1:0]     wdata,
    output logic [WORD_W-1:0]     rdata,
    output logic                  glb_en,
    output logic [SIZE_IDX_W-1:0] size_idx,
    output logic [WORD_W-1:0]     win_lo [NUM_WIN],
    output logic [WORD_W-1:0]     win_hi [NUM_WIN]
);

    logic [WORD_W-1:0]     cmd_q;
    logic [SIZE_IDX_W-1:0] size_q;
    logic [WORD_W-1:0]     rd_mux;

    // Command word: whole-word write, bit CMD_XLAT_BIT drives glb_en.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_en && kind == SEL_CMD) begin
            cmd_q <= wdata;
        end
    end

    // Size index: only the low bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
        end else if (wr_en && kind == SEL_SIZE) begin
            size_q <= wdata[SIZE_IDX_W-1:0];
        end
    end

    // One pair of window words per generated slot.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic sel_g;
        assign sel_g = wr_en && (kind == SEL_WIN) && (win == IDX_W'(g));

        // Update the low or high word of window g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_lo[g] <= '0;
                win_hi[g] <= '0;
            end else if (sel_g) begin
                if (hi_word) begin
                    win_hi[g] <= wdata;
                end else begin
                    win_lo[g] <= wdata;
                end
            end
        end
    end

    // Select the value seen by a read.
    always_comb begin
        unique case (kind)
            SEL_CMD:  rd_mux = cmd_q;
            SEL_SIZE: rd_mux = WORD_W'(size_q);
            SEL_WIN:  rd_mux = hi_word ? win_hi[win] : win_lo[win];
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

    assign glb_en   = cmd_q[CMD_XLAT_BIT];
    assign size_idx = size_q;

    // Command word changes only through its own address.
    p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && kind == SEL_CMD) |=> $stable(cmd_q));

    // Size index changes only through its own address.
    p_size_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && kind == SEL_SIZE) |=> $stable(size_q));

    // Read data holds between reads.
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // Unmapped reads return zero.
    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == SEL_NONE) |=> (rdata == '0));

endmodule

// File: rtl/ob_xlat_lookup.sv
// Translation datapath.
// Finds the window for a local address, checks the range and the enables,
// and builds the wide remote address. Results are registered, so they
// appear one cycle after the request. Assumes REGION_BASE is aligned to
// 1 MB and MB_SHIFT plus the largest size index is below WORD_W.
module ob_xlat_lookup
    import ob_xlat_pkg::*;
#(
    parameter int unsigned WORD_W      = 32,
    parameter int unsigned NUM_WIN     = 32,
    parameter logic [31:0] REGION_BASE = 32'h4000_0000,
    localparam int unsigned IDX_W      = $clog2(NUM_WIN),
    localparam int unsigned OUT_W      = 2 * WORD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  xl_valid,
    input  logic [WORD_W-1:0]     xl_addr,
    input  logic                  glb_en,
    input  logic [SIZE_IDX_W-1:0] size_idx,
    input  logic [WORD_W-1:0]     win_lo [NUM_WIN],
    input  logic [WORD_W-1:0]     win_hi [NUM_WIN],
    output logic                  out_valid,
    output logic                  out_hit,
    output logic                  out_miss,
    output logic [OUT_W-1:0]      out_addr
);

    localparam logic [WORD_W-1:0] BASE_W = WORD_W'(REGION_BASE);

    int unsigned       sh;
    logic [WORD_W-1:0] off;
    logic [WORD_W-1:0] idx_full;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] lo_w;
    logic [WORD_W-1:0] hi_w;
    logic [IDX_W-1:0]  sel;
    logic              in_range;
    logic              hit_d;
    logic [OUT_W-1:0]  addr_d;

    // Window index, in-window offset and the composed remote address.
    always_comb begin
        sh       = MB_SHIFT + 32'(size_idx);
        off      = xl_addr - BASE_W;
        idx_full = off >> sh;
        mask     = (WORD_W'(1) << sh) - WORD_W'(1);
        in_range = (xl_addr >= BASE_W) && (idx_full < WORD_W'(NUM_WIN));
        sel      = idx_full[IDX_W-1:0];
        lo_w     = win_lo[sel];
        hi_w     = win_hi[sel];
        hit_d    = xl_valid && glb_en && in_range && lo_w[WIN_EN_BIT];
        addr_d   = {hi_w, (lo_w & ~mask) | (off & mask)};
    end

    // Register the result flags and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_miss  <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= xl_valid;
            out_hit   <= hit_d;
            out_miss  <= xl_valid && !hit_d;
            out_addr  <= hit_d ? addr_d : '0;
        end
    end

    // A request produces a result on the next cycle.
    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid |=> out_valid);

    // No request means all result flags are quiet.
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_valid |=> (!out_valid && !out_hit && !out_miss));

    // Hit and miss are exclusive and cover every valid result.
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_hit != out_miss));

    // Address is zero without a hit.
    p_miss_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_hit |-> (out_addr == '0));

    // Global enable off forces a miss.
    p_glb_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid && !glb_en) |=> out_miss);

    // Addresses below the region never hit.
    p_below_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid && xl_addr < BASE_W) |=> out_miss);

    // The megabyte offset passes through unchanged on a hit.
    p_low_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> (out_addr[MB_SHIFT-1:0] == $past(xl_addr[MB_SHIFT-1:0])));

endmodule

// File: rtl/ob_xlat_top.sv
// Outbound address window translator, top level.
// Ties the register decoder, the register file and the lookup datapath
// together. A lookup sampled on the same edge as a register write uses
// the pre-write register values.
module ob_xlat_top
    import ob_xlat_pkg::*;
#(
    parameter int unsigned REG_AW      = 12,
    parameter int unsigned WORD_W      = 32,
    parameter int unsigned NUM_WIN     = 32,
    parameter logic [31:0] REGION_BASE = 32'h4000_0000,
    localparam int unsigned IDX_W      = $clog2(NUM_WIN),
    localparam int unsigned OUT_W      = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              xl_valid,
    input  logic [WORD_W-1:0] xl_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic              out_miss,
    output logic [OUT_W-1:0]  out_addr
);

    reg_sel_e              dec_kind;
    logic                  dec_hi;
    logic [IDX_W-1:0]      dec_win;
    logic                  glb_en;
    logic [SIZE_IDX_W-1:0] size_idx;
    logic [WORD_W-1:0]     win_lo [NUM_WIN];
    logic [WORD_W-1:0]     win_hi [NUM_WIN];

    ob_xlat_decode #(
        .REG_AW  (REG_AW),
        .NUM_WIN (NUM_WIN)
    ) u_decode (
        .addr    (reg_addr),
        .kind    (dec_kind),
        .hi_word (dec_hi),
        .win     (dec_win)
    );

    ob_xlat_regs #(
        .WORD_W  (WORD_W),
        .NUM_WIN (NUM_WIN)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .rd_en    (reg_rd_en),
        .kind     (dec_kind),
        .hi_word  (dec_hi),
        .win      (dec_win),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .glb_en   (glb_en),
        .size_idx (size_idx),
        .win_lo   (win_lo),
        .win_hi   (win_hi)
    );

    ob_xlat_lookup #(
        .WORD_W      (WORD_W),
        .NUM_WIN     (NUM_WIN),
        .REGION_BASE (REGION_BASE)
    ) u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .xl_valid  (xl_valid),
        .xl_addr   (xl_addr),
        .glb_en    (glb_en),
        .size_idx  (size_idx),
        .win_lo    (win_lo),
        .win_hi    (win_hi),
        .out_valid (out_valid),
        .out_hit   (out_hit),
        .out_miss  (out_miss),
        .out_addr  (out_addr)
    );

endmodule

// File: tb/ob_xlat_top_bench.sv
// Self-checking bench for the outbound window translator.
module ob_xlat_top_bench;

    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam int NW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xl_valid = 1'b0;
    logic [31:0] xl_addr = '0;
    logic        out_valid;
    logic        out_hit;
    logic        out_miss;
    logic [63:0] out_addr;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_lo [NW];
    logic [31:0] m_hi [NW];
    logic [31:0] m_cmd;
    logic [2:0]  m_sz;

    always #5 clk = ~clk;

    ob_xlat_top u_ob_xlat_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .xl_valid  (xl_valid),
        .xl_addr   (xl_addr),
        .out_valid (out_valid),
        .out_hit   (out_hit),
        .out_miss  (out_miss),
        .out_addr  (out_addr)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply a register write to the model, as the requirements define it.
    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        if (a == 12'h004) m_cmd = d;
        else if (a == 12'h030) m_sz = d[2:0];
        else if (a[1:0] == 2'b00 && a >= 12'h200 && a < 12'h300) begin
            if (a[2]) m_hi[(a - 12'h200) >> 3] = d;
            else      m_lo[(a - 12'h200) >> 3] = d;
        end
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        if (a == 12'h004) return m_cmd;
        if (a == 12'h030) return {29'd0, m_sz};
        if (a[1:0] == 2'b00 && a >= 12'h200 && a < 12'h300)
            return a[2] ? m_hi[(a - 12'h200) >> 3] : m_lo[(a - 12'h200) >> 3];
        return 32'd0;
    endfunction

    // Expected lookup result from the model state.
    task automatic model_xlat(input logic [31:0] a, output logic hit, output logic [63:0] o);
        logic [31:0] off, idx, mask;
        int sh;
        sh   = 20 + int'(m_sz);
        off  = a - BASE;
        idx  = off >> sh;
        mask = (32'd1 << sh) - 32'd1;
        hit  = 1'b0;
        o    = '0;
        if (a >= BASE && idx < NW && m_cmd[1] && m_lo[idx[4:0]][0]) begin
            hit = 1'b1;
            o   = {m_hi[idx[4:0]], (m_lo[idx[4:0]] & ~mask) | (off & mask)};
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic reg_read(input logic [11:0] a, input string tag);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        check(tag, 64'(reg_rdata), 64'(model_read(a)));
    endtask

    task automatic do_xlat(input logic [31:0] a, input string tag);
        logic eh;
        logic [63:0] eo;
        model_xlat(a, eh, eo);
        @(negedge clk);
        xl_valid = 1'b1; xl_addr = a;
        @(negedge clk);
        xl_valid = 1'b0;
        check({tag, " valid"}, 64'(out_valid), 64'd1);
        check({tag, " hit"}, 64'(out_hit), 64'(eh));
        check({tag, " miss"}, 64'(out_miss), 64'(!eh));
        check({tag, " addr"}, out_addr, eo);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < NW; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        m_cmd = '0; m_sz = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        reg_read(12'h004, "R1 cmd");
        reg_read(12'h030, "R1 size");
        reg_read(12'h200, "R1 win0 lo");
        reg_read(12'h2FC, "R1 win31 hi");
        do_xlat(BASE + 32'h10, "R1 lookup");

        // Program windows with translation still off.
        reg_write(12'h200, 32'hA000_0001);
        reg_write(12'h204, 32'h0000_0001);
        reg_write(12'h2F8, 32'h7770_0001);
        reg_write(12'h2FC, 32'hDEAD_BEEF);
        reg_write(12'h228, 32'h1230_0000);
        reg_write(12'h22C, 32'h0000_0055);
        reg_write(12'h218, 32'h5550_0001);
        reg_write(12'h21C, 32'h0000_0033);
        do_xlat(BASE + 32'h12345, "R7 global off");

        // R3: other command bits set, enable bit clear.
        reg_write(12'h004, 32'hFFFF_FFFD);
        do_xlat(BASE + 32'h12345, "R3 bit1 clear");
        reg_write(12'h004, 32'h0000_00F2);
        reg_read(12'h004, "R2 cmd readback");

        // R4/R5 at 1 MB windows.
        do_xlat(BASE + 32'h12345, "R5 window0");
        do_xlat(BASE + 32'h01FF_FFFF, "R4 last window top");
        do_xlat(BASE + 32'h0200_0000, "R8 past end");
        do_xlat(BASE - 32'h1, "R8 below base");
        do_xlat(BASE + 32'h0050_0000, "R6 disabled window");
        reg_read(12'h228, "R2 win5 lo");

        // R12: unmapped and misaligned addresses.
        reg_write(12'h100, 32'hFFFF_FFFF);
        reg_read(12'h100, "R12 unmapped");
        reg_write(12'h201, 32'h0);
        reg_read(12'h200, "R12 misaligned no alias");
        reg_write(12'h300, 32'h0);
        reg_read(12'h004, "R3 cmd unchanged");

        // R2: size keeps three bits; R4 with 4 MB windows.
        reg_write(12'h030, 32'hFFFF_FFFA);
        reg_read(12'h030, "R2 size width");
        reg_write(12'h030, 32'h2);
        do_xlat(BASE + 32'h00C0_0000 + 32'h002A_BCDE, "R4 4MB window3");
        do_xlat(BASE + 32'h0800_0000, "R8 4MB past end");
        do_xlat(BASE + 32'h07FF_FFFF, "R4 4MB last byte");
        reg_write(12'h030, 32'h0);

        // R11: write and lookup in the same cycle.
        begin
            logic eh;
            logic [63:0] eo;
            model_xlat(BASE + 32'h20, eh, eo);
            @(negedge clk);
            reg_wr_en = 1'b1; reg_addr = 12'h200; reg_wdata = 32'hA000_0000;
            xl_valid = 1'b1; xl_addr = BASE + 32'h20;
            @(negedge clk);
            reg_wr_en = 1'b0; xl_valid = 1'b0;
            model_write(12'h200, 32'hA000_0000);
            check("R11 old hit", 64'(out_hit), 64'(eh));
            check("R11 old addr", out_addr, eo);
            @(negedge clk);
            check("R9 idle valid", 64'(out_valid), 64'd0);
            check("R9 idle miss", 64'(out_miss), 64'd0);
            do_xlat(BASE + 32'h20, "R11 new miss");
        end

        // Random mix of writes and lookups.
        for (int n = 0; n < 400; n++) begin
            int unsigned r;
            r = $urandom % 10;
            if (r == 0) begin
                int unsigned k;
                k = $urandom % NW;
                reg_write(12'(12'h200 + 8 * k), $urandom);
                reg_write(12'(12'h204 + 8 * k), $urandom);
            end else if (r == 1) begin
                reg_write(12'h030, $urandom);
            end else if (r == 2) begin
                reg_write(12'h004, ($urandom % 8 == 0) ? 32'h0 : 32'h2);
            end else if (r == 3) begin
                // Same-cycle write and lookup (R11).
                logic eh;
                logic [63:0] eo;
                logic [31:0] a, d;
                int unsigned k;
                k = $urandom % NW;
                d = $urandom;
                a = BASE + ($urandom % (32'(NW) << (20 + int'(m_sz))));
                model_xlat(a, eh, eo);
                @(negedge clk);
                reg_wr_en = 1'b1; reg_addr = 12'(12'h200 + 8 * k); reg_wdata = d;
                xl_valid = 1'b1; xl_addr = a;
                @(negedge clk);
                reg_wr_en = 1'b0; xl_valid = 1'b0;
                model_write(12'(12'h200 + 8 * k), d);
                check("R11 random hit", 64'(out_hit), 64'(eh));
                check("R11 random addr", out_addr, eo);
            end else begin
                logic [63:0] span;
                logic [31:0] a;
                span = 64'(NW + 2) << (20 + int'(m_sz));
                if ($urandom % 10 == 0) a = $urandom;
                else a = BASE + 32'((64'($urandom) * 64'd7) % span);
                do_xlat(a, "R5 random");
            end
        end
        reg_read(12'h030, "R2 final size");
        reg_read(12'h004, "R2 final cmd");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule